// File: doc/BRIEF.md
# Bit-Granular Stream Port

This block lets a processor pull bit fields of any width from 0 to 16 bits out of byte memory, and push such fields into it, through byte-wide register accesses. It keeps two separate contexts. The fetch context serves every processor read of a field register. The store context serves every processor write of a field register. Software can therefore unpack one stream while it packs another, which is the usual pattern for a copy loop or a decompressor. Each context has a 32-bit bit cursor. The cursor moves forward by the number of bits moved on every field access, and it never moves backwards. Bits are packed MSB-first inside each byte. A fetched field is returned right-aligned and zero-extended.

The field width is not held in a control register. It is chosen by the register address the processor touches. Each width from 0 to 16 has a low/high byte pair in a field window. Reading the low byte of a pair starts a fetch of the whole field and holds the processor with a wait signal until the field is in. That same read latches the high byte, which a later read of the odd address returns. Writing the low byte only stages it. Writing the high byte hands the whole field to a write buffer, and the buffer merges it into memory with read-modify-write cycles. The processor is held only when it commits a new field while the buffer is still busy. Two skip registers move either cursor forward by 0 to 65535 bits without touching memory. Both cursors can be loaded and read back byte by byte. Memory is reached through a byte request/acknowledge port. Either engine can drive that port, but never both at the same time.

Top module: `bitstream_port`

## Requirements
- R1: After reset both cursors read back as zero, `cpu_wait` is low and no memory request is raised.
- R2: The fetch cursor is at addresses 0 to 3 and the store cursor at addresses 4 to 7, least significant byte first. A processor write to any of these bytes replaces that byte, and a read returns it.
- R3: A read of the even address FIELD_BASE+2w (w = 0..16) returns bits 7:0 of the w-bit field that starts at the fetch cursor. Bit k of the stream is bit 7-(k mod 8) of byte k/8, and the field is right-aligned and zero-extended. The fetch cursor then advances by w.
- R4: A read of the odd address FIELD_BASE+2w+1 returns bits 15:8 of the last fetched field. It starts no fetch and leaves the fetch cursor unchanged.
- R5: Width 0 moves no data. Its read returns 0 and its write changes no memory byte, and neither access changes a cursor.
- R6: A write to FIELD_BASE+2w stages a byte. A write to FIELD_BASE+2w+1 commits {that byte, staged byte} as a w-bit field at the store cursor, using the same bit order as R3. Memory bits outside the field keep their values, and the store cursor advances by w.
- R7: Writing the low then the high byte of the skip register at address 8 (fetch) or address 10 (store) advances that cursor by the 16-bit amount, modulo 2^32.
- R8: A field read holds `cpu_wait` high until its data is ready. A field commit raises no wait while the write buffer is idle. A commit that arrives while the buffer is busy is held until the buffer drains.
- R9: Field reads and fetch skips never change the store cursor. Field writes and store skips never change the fetch cursor.
- R10: Once `mem_req` is raised, it stays high with a stable address, direction and write data until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | AW | Register byte address |
| cpu_rd | input | 1 | Read request, held until `cpu_wait` is low |
| cpu_wr | input | 1 | Write request, held until `cpu_wait` is low |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid when `cpu_rd` is high and `cpu_wait` is low |
| cpu_wait | output | 1 | Holds the current processor access |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | High for a memory write |
| mem_addr | output | PTR_W-3 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completes the request in this cycle |

## Verification
The assertions assume the processor never raises `cpu_rd` and `cpu_wr` in the same cycle. They also assume it keeps address and data steady while `cpu_wait` is high, and that memory answers each request with exactly one `mem_ack` pulse. The bench's bus tasks drive only one strobe at a time and drop it one step after the completing edge. The memory model raises a single registered acknowledge after a random delay and never acknowledges a request that is not raised. The cursor-hold properties also depend on software not rewriting a cursor byte in the same cycle as a field access on the other context. A single processor bus makes that impossible.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  typedef enum logic [1:0] {F_IDLE, F_REQ, F_FIN} fetch_st_t;
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} store_st_t;
  typedef enum logic [1:0] {H_IDLE, H_BUSY, H_DONE} hold_st_t;
endpackage

// File: rtl/bsp_fetch.sv
module bsp_fetch
  import bsp_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int MAX_W = 16,
  parameter int WID_W = 5,
  parameter int SPAN  = 3,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PTR_W-1:0] bitptr,
  input  logic [WID_W-1:0] width,
  output logic             busy,
  output logic             done,
  output logic [MAX_W-1:0] field,
  output logic             mem_req,
  output logic [PTR_W-4:0] mem_addr,
  input  logic [7:0]       mem_rdata,
  input  logic             mem_ack
);
  localparam int BUF_W = SPAN * 8;
  localparam int SH_W  = $clog2(BUF_W + 1);
  localparam int BA_W  = PTR_W - 3;

  fetch_st_t        st;
  logic [BA_W-1:0]  base;
  logic [2:0]       off;
  logic [WID_W-1:0] wid;
  logic [CNT_W-1:0] nb, idx;
  logic [BUF_W-1:0] gather;

  // bytes touched by the requested field
  logic [WID_W+1:0] span_bits;
  logic [CNT_W-1:0] nb_c, idx_nx;
  logic [SH_W-1:0]  lane_sh, out_sh;
  logic [MAX_W:0]   mask_p1;
  logic [MAX_W-1:0] fmask;

  always_comb begin
    span_bits = (WID_W+2)'(bitptr[2:0]) + (WID_W+2)'(width) + (WID_W+2)'(7);
    nb_c      = (width == '0) ? '0 : CNT_W'(span_bits >> 3);
    idx_nx    = idx + 1'b1;
    lane_sh   = SH_W'(8 * (SPAN - 1)) - (SH_W'(idx) << 3);
    out_sh    = SH_W'(BUF_W) - SH_W'(off) - SH_W'(wid);
    mask_p1   = (MAX_W+1)'(1) << wid;
    fmask     = MAX_W'(mask_p1 - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= F_IDLE;
      base   <= '0;
      off    <= '0;
      wid    <= '0;
      nb     <= '0;
      idx    <= '0;
      gather <= '0;
    end else begin
      case (st)
        F_IDLE: if (start) begin
          base   <= bitptr[PTR_W-1:3];
          off    <= bitptr[2:0];
          wid    <= width;
          nb     <= nb_c;
          idx    <= '0;
          gather <= '0;
          st     <= (nb_c == '0) ? F_FIN : F_REQ;
        end
        F_REQ: if (mem_ack) begin
          gather <= gather | (BUF_W'(mem_rdata) << lane_sh);
          idx    <= idx_nx;
          if (idx_nx == nb) st <= F_FIN;
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  assign busy     = (st != F_IDLE);
  assign done     = (st == F_FIN);
  assign mem_req  = (st == F_REQ);
  assign mem_addr = base + BA_W'(idx);
  assign field    = MAX_W'(gather >> out_sh) & fmask;
endmodule

// File: rtl/bsp_store.sv
module bsp_store
  import bsp_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int MAX_W = 16,
  parameter int WID_W = 5,
  parameter int SPAN  = 3,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PTR_W-1:0] bitptr,
  input  logic [WID_W-1:0] width,
  input  logic [MAX_W-1:0] data,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PTR_W-4:0] mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  input  logic             mem_ack
);
  localparam int BUF_W = SPAN * 8;
  localparam int SH_W  = $clog2(BUF_W + 1);
  localparam int BA_W  = PTR_W - 3;

  store_st_t        st;
  logic [BA_W-1:0]  base;
  logic [CNT_W-1:0] nb, idx;
  logic [BUF_W-1:0] fpos, mpos;
  logic [7:0]       merged;

  logic [WID_W+1:0] span_bits;
  logic [CNT_W-1:0] nb_c, idx_nx;
  logic [SH_W-1:0]  lane_sh, in_sh;
  logic [MAX_W:0]   mask_p1;
  logic [MAX_W-1:0] fmask;
  logic [7:0]       lane_f, lane_m;

  always_comb begin
    span_bits = (WID_W+2)'(bitptr[2:0]) + (WID_W+2)'(width) + (WID_W+2)'(7);
    nb_c      = (width == '0) ? '0 : CNT_W'(span_bits >> 3);
    idx_nx    = idx + 1'b1;
    in_sh     = SH_W'(BUF_W) - SH_W'(bitptr[2:0]) - SH_W'(width);
    mask_p1   = (MAX_W+1)'(1) << width;
    fmask     = MAX_W'(mask_p1 - 1'b1);
    lane_sh   = SH_W'(8 * (SPAN - 1)) - (SH_W'(idx) << 3);
    lane_f    = 8'(fpos >> lane_sh);
    lane_m    = 8'(mpos >> lane_sh);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      base   <= '0;
      nb     <= '0;
      idx    <= '0;
      fpos   <= '0;
      mpos   <= '0;
      merged <= '0;
    end else begin
      case (st)
        S_IDLE: if (start && nb_c != '0) begin
          base <= bitptr[PTR_W-1:3];
          nb   <= nb_c;
          idx  <= '0;
          fpos <= BUF_W'(data & fmask) << in_sh;
          mpos <= BUF_W'(fmask) << in_sh;
          st   <= S_RD;
        end
        S_RD: if (mem_ack) begin
          merged <= (mem_rdata & ~lane_m) | lane_f;
          st     <= S_WR;
        end
        S_WR: if (mem_ack) begin
          idx <= idx_nx;
          st  <= (idx_nx == nb) ? S_IDLE : S_RD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign mem_req   = (st != S_IDLE);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = base + BA_W'(idx);
  assign mem_wdata = merged;
endmodule

// File: rtl/bsp_memsel.sv
module bsp_memsel #(
  parameter int BA_W = 29
) (
  input  logic            f_req,
  input  logic [BA_W-1:0] f_addr,
  output logic            f_ack,
  input  logic            s_req,
  input  logic            s_we,
  input  logic [BA_W-1:0] s_addr,
  input  logic [7:0]      s_wdata,
  output logic            s_ack,
  output logic            mem_req,
  output logic            mem_we,
  output logic [BA_W-1:0] mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic            mem_ack
);
  // engines are mutually exclusive; the store engine wins if both ever ask
  always_comb begin
    mem_req   = f_req | s_req;
    mem_we    = s_req & s_we;
    mem_addr  = s_req ? s_addr : f_addr;
    mem_wdata = s_wdata;
    s_ack     = mem_ack & s_req;
    f_ack     = mem_ack & f_req & ~s_req;
  end
endmodule

// File: rtl/bitstream_port.sv
module bitstream_port
  import bsp_pkg::*;
#(
  parameter int PTR_W      = 32,
  parameter int MAX_W      = 16,
  parameter int AW         = 7,
  parameter int FIELD_BASE = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    cpu_addr,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  input  logic [7:0]       cpu_wdata,
  output logic [7:0]       cpu_rdata,
  output logic             cpu_wait,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PTR_W-4:0] mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  input  logic             mem_ack
);
  localparam int WID_W  = $clog2(MAX_W + 1);
  localparam int SPAN   = (MAX_W + 14) / 8;
  localparam int CNT_W  = $clog2(SPAN + 1);
  localparam int NFIELD = MAX_W + 1;
  localparam int PB     = PTR_W / 8;
  localparam int PB_W   = $clog2(PB);
  localparam int BA_W   = PTR_W - 3;
  localparam logic [AW-1:0] A_WPTR  = AW'(PB);
  localparam logic [AW-1:0] A_RSKIP = AW'(2 * PB);
  localparam logic [AW-1:0] A_WSKIP = AW'(2 * PB + 2);
  localparam logic [AW-1:0] A_FB    = AW'(FIELD_BASE);
  localparam logic [AW-1:0] A_FEND  = AW'(FIELD_BASE + 2 * NFIELD);

  logic [PTR_W-1:0] rptr, wptr;
  logic [15:0]      rd_lat;
  logic [7:0]       wr_lo, rskip_lo, wskip_lo;
  hold_st_t         hst;

  // address decode
  logic             in_field, is_hi, is_rptr, is_wptr;
  logic [AW-1:0]    foff;
  logic [WID_W-1:0] fw;
  logic [PB_W-1:0]  psel;
  logic             rd_start, wr_commit, wr_ok;

  logic             f_busy, f_done, f_req, f_ack;
  logic [MAX_W-1:0] f_field;
  logic [BA_W-1:0]  f_addr;
  logic             s_busy, s_req, s_we, s_ack;
  logic [BA_W-1:0]  s_addr;
  logic [7:0]       s_wdata;

  always_comb begin
    in_field  = (cpu_addr >= A_FB) && (cpu_addr < A_FEND);
    foff      = cpu_addr - A_FB;
    fw        = WID_W'(foff >> 1);
    is_hi     = cpu_addr[0];
    is_rptr   = (cpu_addr < A_WPTR);
    is_wptr   = (cpu_addr >= A_WPTR) && (cpu_addr < A_RSKIP);
    psel      = cpu_addr[PB_W-1:0];
    rd_start  = cpu_rd && in_field && !is_hi && (hst == H_IDLE) && !s_busy;
    cpu_wait  = (cpu_rd && in_field && !is_hi && (hst != H_DONE)) ||
                (cpu_wr && in_field && is_hi && s_busy);
    wr_ok     = cpu_wr && !cpu_wait;
    wr_commit = wr_ok && in_field && is_hi;
  end

  always_comb begin
    cpu_rdata = '0;
    if (is_rptr)       cpu_rdata = rptr[{psel, 3'b000} +: 8];
    else if (is_wptr)  cpu_rdata = wptr[{psel, 3'b000} +: 8];
    else if (in_field) cpu_rdata = is_hi ? rd_lat[15:8] : rd_lat[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr     <= '0;
      wptr     <= '0;
      rd_lat   <= '0;
      wr_lo    <= '0;
      rskip_lo <= '0;
      wskip_lo <= '0;
      hst      <= H_IDLE;
    end else begin
      case (hst)
        H_IDLE: if (rd_start) begin
          rptr <= rptr + PTR_W'(fw);
          hst  <= H_BUSY;
        end
        H_BUSY: if (f_done) begin
          rd_lat <= 16'(f_field);
          hst    <= H_DONE;
        end
        default: hst <= H_IDLE;
      endcase
      if (wr_ok) begin
        if (is_rptr) begin
          for (int b = 0; b < PB; b++)
            if (psel == PB_W'(b)) rptr[8*b +: 8] <= cpu_wdata;
        end else if (is_wptr) begin
          for (int b = 0; b < PB; b++)
            if (psel == PB_W'(b)) wptr[8*b +: 8] <= cpu_wdata;
        end else if (cpu_addr == A_RSKIP) begin
          rskip_lo <= cpu_wdata;
        end else if (cpu_addr == A_RSKIP + 1'b1) begin
          rptr <= rptr + PTR_W'({cpu_wdata, rskip_lo});
        end else if (cpu_addr == A_WSKIP) begin
          wskip_lo <= cpu_wdata;
        end else if (cpu_addr == A_WSKIP + 1'b1) begin
          wptr <= wptr + PTR_W'({cpu_wdata, wskip_lo});
        end else if (in_field && !is_hi) begin
          wr_lo <= cpu_wdata;
        end else if (wr_commit) begin
          wptr <= wptr + PTR_W'(fw);
        end
      end
    end
  end

  bsp_fetch #(.PTR_W(PTR_W), .MAX_W(MAX_W), .WID_W(WID_W), .SPAN(SPAN), .CNT_W(CNT_W)) u_fetch (
    .clk(clk), .rst(rst), .start(rd_start), .bitptr(rptr), .width(fw),
    .busy(f_busy), .done(f_done), .field(f_field),
    .mem_req(f_req), .mem_addr(f_addr), .mem_rdata(mem_rdata), .mem_ack(f_ack)
  );

  bsp_store #(.PTR_W(PTR_W), .MAX_W(MAX_W), .WID_W(WID_W), .SPAN(SPAN), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst(rst), .start(wr_commit), .bitptr(wptr), .width(fw),
    .data(MAX_W'({cpu_wdata, wr_lo})), .busy(s_busy),
    .mem_req(s_req), .mem_we(s_we), .mem_addr(s_addr), .mem_wdata(s_wdata),
    .mem_rdata(mem_rdata), .mem_ack(s_ack)
  );

  bsp_memsel #(.BA_W(BA_W)) u_sel (
    .f_req(f_req), .f_addr(f_addr), .f_ack(f_ack),
    .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_ack(s_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack)
  );
endmodule

// File: rtl/bsp_checker.sv
module bsp_checker #(
  parameter int PTR_W      = 32,
  parameter int MAX_W      = 16,
  parameter int AW         = 7,
  parameter int FIELD_BASE = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    cpu_addr,
  input logic             cpu_rd,
  input logic             cpu_wr,
  input logic             cpu_wait,
  input logic             mem_req,
  input logic             mem_we,
  input logic [PTR_W-4:0] mem_addr,
  input logic [7:0]       mem_wdata,
  input logic             mem_ack,
  input logic [PTR_W-1:0] rptr,
  input logic [PTR_W-1:0] wptr,
  input logic             f_busy,
  input logic             s_busy
);
  localparam logic [AW-1:0] C_FB   = AW'(FIELD_BASE);
  localparam logic [AW-1:0] C_FEND = AW'(FIELD_BASE + 2 * (MAX_W + 1));

  logic hi_field;
  assign hi_field = (cpu_addr >= C_FB) && (cpu_addr < C_FEND) && cpu_addr[0];

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!mem_req && !f_busy && !s_busy));

  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r8_commit_no_stall: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !s_busy) |-> !cpu_wait);

  a_r8_one_engine: assert property (@(posedge clk) disable iff (rst)
    !(f_busy && s_busy));

  a_r9_store_cursor_hold: assert property (@(posedge clk) disable iff (rst)
    !cpu_wr |=> $stable(wptr));

  a_r9_fetch_cursor_hold: assert property (@(posedge clk) disable iff (rst)
    (!cpu_rd && !cpu_wr) |=> $stable(rptr));

  a_r5_zero_read_hold: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr == C_FB) |=> $stable(rptr));

  a_r4_high_read_hold: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && hi_field) |=> $stable(rptr));
endmodule

bind bitstream_port bsp_checker #(.PTR_W(PTR_W), .MAX_W(MAX_W), .AW(AW), .FIELD_BASE(FIELD_BASE)) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .cpu_wait(cpu_wait), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack), .rptr(rptr), .wptr(wptr),
  .f_busy(f_busy), .s_busy(s_busy)
);

// File: tb/bitstream_port_test.sv
module bitstream_port_test;
  localparam int FB = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_wait;
  logic        mem_req, mem_we, mem_ack;
  logic [28:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [7:0]  dmem [256];
  logic [7:0]  gmem [256];
  logic        ack_q = 1'b0;
  logic [7:0]  rdq = '0;
  int          checks = 0, errors = 0;
  logic [31:0] rp = 0, wp = 0;

  always #10 clk = ~clk;

  bitstream_port uut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  assign mem_ack   = ack_q;
  assign mem_rdata = rdq;

  // byte memory with a random acknowledge delay
  always @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else if (mem_req && !ack_q && ($urandom % 3 != 0)) begin
      ack_q <= 1'b1;
      rdq   <= dmem[mem_addr[7:0]];
    end else ack_q <= 1'b0;
    if (!rst && ack_q && mem_req && mem_we) dmem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [6:0] a, input logic [7:0] d, output bit stalled);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; stalled = 1'b0;
    #1;
    while (cpu_wait) begin stalled = 1'b1; @(negedge clk); #1; end
    @(posedge clk); #1;
    cpu_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [6:0] a, output logic [7:0] d, output bit stalled);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1; stalled = 1'b0;
    #1;
    while (cpu_wait) begin stalled = 1'b1; @(negedge clk); #1; end
    d = cpu_rdata;
    @(posedge clk); #1;
    cpu_rd = 1'b0;
  endtask

  task automatic set_ptr(input bit store, input logic [31:0] v);
    bit s;
    for (int b = 0; b < 4; b++) bus_wr(7'(b + (store ? 4 : 0)), v[8*b +: 8], s);
    if (store) wp = v; else rp = v;
  endtask

  task automatic get_ptr(input bit store, output logic [31:0] v);
    bit s; logic [7:0] d;
    for (int b = 0; b < 4; b++) begin bus_rd(7'(b + (store ? 4 : 0)), d, s); v[8*b +: 8] = d; end
  endtask

  function automatic logic [15:0] gread(input logic [31:0] p, input int w);
    logic [15:0] v = '0;
    for (int k = 0; k < w; k++) begin
      logic [31:0] q = p + 32'(k);
      v = {v[14:0], gmem[q[10:3]][3'd7 - q[2:0]]};
    end
    return v;
  endfunction

  task automatic gwrite(input logic [31:0] p, input int w, input logic [15:0] val);
    for (int k = 0; k < w; k++) begin
      logic [31:0] q = p + 32'(k);
      gmem[q[10:3]][3'd7 - q[2:0]] = val[w-1-k];
    end
  endtask

  task automatic rd_field(input int w, output logic [15:0] v, output bit stalled);
    logic [7:0] lo, hi; bit s2;
    bus_rd(7'(FB + 2*w), lo, stalled);
    bus_rd(7'(FB + 2*w + 1), hi, s2);
    v = {hi, lo};
  endtask

  task automatic wr_field(input int w, input logic [15:0] v, output bit stalled);
    bit s1;
    bus_wr(7'(FB + 2*w), v[7:0], s1);
    bus_wr(7'(FB + 2*w + 1), v[15:8], stalled);
    gwrite(wp, w, v);
    wp = wp + 32'(w);
  endtask

  task automatic do_read(input string req, input int w);
    logic [15:0] v, e; bit s;
    e = gread(rp, w);
    rd_field(w, v, s);
    chk(req, $sformatf("read w=%0d at %0d", w, rp), {16'h0, v}, {16'h0, e});
    rp = rp + 32'(w);
  endtask

  task automatic skip(input bit store, input logic [15:0] n);
    bit s;
    bus_wr(store ? 7'd10 : 7'd8, n[7:0], s);
    bus_wr(store ? 7'd11 : 7'd9, n[15:8], s);
    if (store) wp = wp + 32'(n); else rp = rp + 32'(n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] p;
    logic [15:0] v;
    logic [7:0]  d;
    bit s;
    int mism;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin dmem[i] = 8'(i * 37 + 11); gmem[i] = 8'(i * 37 + 11); end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    #5;
    chk("R1", "wait after reset", {31'b0, cpu_wait}, 0);
    chk("R1", "mem_req after reset", {31'b0, mem_req}, 0);
    get_ptr(0, p); chk("R1", "fetch cursor", p, 0);
    get_ptr(1, p); chk("R1", "store cursor", p, 0);

    // R2 cursor load and readback
    set_ptr(0, 32'h89AB_CDEF); get_ptr(0, p); chk("R2", "fetch cursor readback", p, 32'h89AB_CDEF);
    set_ptr(1, 32'h0123_4567); get_ptr(1, p); chk("R2", "store cursor readback", p, 32'h0123_4567);
    bus_wr(7'd2, 8'h5A, s); get_ptr(0, p); chk("R2", "single byte replace", p, 32'h895A_CDEF);

    // R7 skip, including carry over 16 bits and 32-bit wrap
    set_ptr(0, 32'h0000_0080); skip(0, 16'hFFFF); get_ptr(0, p); chk("R7", "fetch skip 65535", p, 32'h0001_007F);
    set_ptr(1, 32'hFFFF_FFF0); skip(1, 16'h0020); get_ptr(1, p); chk("R7", "store skip wraps", p, 32'h0000_0010);
    skip(1, 16'h0000); get_ptr(1, p); chk("R7", "store skip zero", p, 32'h0000_0010);

    // R3 directed field reads
    set_ptr(0, 0);
    do_read("R3", 8);
    do_read("R3", 3);
    do_read("R3", 16);
    do_read("R3", 1);
    do_read("R3", 16);
    get_ptr(0, p); chk("R3", "cursor after reads", p, 32'd44);

    // R8 reads stall
    rd_field(5, v, s); rp = rp + 5;
    chk("R8", "field read stalled", {31'b0, s}, 1);

    // R4 high byte reread without fetch
    rd_field(13, v, s); rp = rp + 13;
    bus_rd(7'(FB + 27), d, s);
    chk("R4", "high byte reread", {24'b0, d}, {24'b0, v[15:8]});
    get_ptr(0, p); chk("R4", "cursor after reread", p, rp);

    // R5 zero width
    rd_field(0, v, s);
    chk("R5", "zero read data", {16'b0, v}, 0);
    get_ptr(0, p); chk("R5", "fetch cursor after zero read", p, rp);
    set_ptr(1, 32'd99);
    bus_wr(7'(FB), 8'hFF, s); bus_wr(7'(FB + 1), 8'hFF, s);
    get_ptr(1, p); chk("R5", "store cursor after zero write", p, 32'd99);

    // R6 writes with preservation, R8 commit timing, R9 independence
    set_ptr(0, 32'd500);
    wr_field(11, 16'h05A3, s);
    chk("R8", "commit on idle buffer not stalled", {31'b0, s}, 0);
    wr_field(16, 16'hBEEF, s);
    chk("R8", "commit on busy buffer stalled", {31'b0, s}, 1);
    wr_field(1, 16'h0001, s);
    wr_field(7, 16'h0055, s);
    get_ptr(1, p); chk("R6", "store cursor advance", p, 32'd134);
    get_ptr(0, p); chk("R9", "fetch cursor untouched by writes", p, 32'd500);
    set_ptr(0, 32'd99);
    do_read("R6", 11);
    do_read("R6", 16);
    do_read("R6", 1);
    do_read("R6", 7);
    get_ptr(1, p); chk("R9", "store cursor untouched by reads", p, 32'd134);

    // constrained random mix
    for (int it = 0; it < 300; it++) begin
      int op = int'($urandom % 4);
      int w  = int'($urandom % 17);
      if (rp > 1900) set_ptr(0, $urandom % 300);
      if (wp > 1900) set_ptr(1, $urandom % 300);
      case (op)
        0: do_read("R3", w);
        1: wr_field(w, 16'($urandom), s);
        2: skip(0, 16'($urandom % 40));
        default: skip(1, 16'($urandom % 40));
      endcase
    end
    get_ptr(0, p); chk("R9", "fetch cursor after random mix", p, rp);
    get_ptr(1, p); chk("R6", "store cursor after random mix", p, wp);

    // R10 / R6 whole memory image matches the bit-level model
    repeat (20) @(posedge clk);
    mism = 0;
    for (int i = 0; i < 256; i++) if (dmem[i] !== gmem[i]) mism++;
    chk("R10", "memory image mismatches", 32'(mism), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule